// File: doc/BRIEF.md
# Set-Associative Data Cache with Selectable Write Policy

This block sits between a processor load/store port and a next-level memory port. It holds `SETS` sets of `WAYS` lines each, and every line stores one block of `BLOCK_BYTES` bytes. The byte address has three fields. The bottom field is the offset inside a block, the middle field picks a set, and the rest forms the tag. On each request the block reads one set, compares the tag against every way of that set at once, and returns the addressed word. When no way matches, the least recently used way of the set is replaced by a whole block read from the next level.

A static `wb_mode` input selects one of two write policies. When high, the cache is write-back with write-allocate: write hits stay in the cache and mark the line dirty, and a write miss first fetches the block. When low, the cache is write-through with no write-allocate: write hits update both the line and memory, and write misses go only to memory. Before the replacement block is requested, a dirty victim is written back as a full block. `wb_mode` must be held constant from reset onward.

A single state machine drives the block. **IDLE** accepts a request (IDLE→LOOKUP). **LOOKUP** compares the tags:
- A read hit, or a write hit in write-back mode, goes to DONE.
- A write hit or write miss in write-through mode goes to THRU.
- Any other miss goes to EVICT when the victim is dirty, or to FETCH otherwise.

**EVICT** writes the victim block (EVICT→FETCH on memory ready). **FETCH** requests the block (FETCH→FILL on ready). **FILL** installs the returned block (FILL→LOOKUP on memory response), and the lookup then hits. **THRU** sends one word to memory (THRU→DONE on ready). **DONE** presents the one-cycle response (DONE→IDLE).

Top module: `cache_sa`

## Requirements
- R1: The byte address splits into offset = addr[OFF_W-1:0] with OFF_W = log2(BLOCK_BYTES), set = the next log2(SETS) bits, and tag = the remaining top bits. The word inside a block is offset[OFF_W-1:log2(WORD_BYTES)], and the lowest log2(WORD_BYTES) address bits do not change which word is returned.
- R2: A hit needs a valid line in the indexed set whose tag matches. A read hit returns the stored word with `resp_hit`=1 and causes no next-level write.
- R3: A read miss issues one next-level read with a block-aligned address, installs the whole returned block, and returns the requested word with `resp_hit`=0.
- R4: On a miss the victim is the way of the set whose last hit or fill is oldest. Hits and fills both refresh a way's recency.
- R5: In write-back mode (`wb_mode`=1), a write hit updates only the cache and marks the line dirty. It makes no next-level write and responds with `resp_hit`=1.
- R6: In write-back mode, a write miss fetches the block, then writes the word into the cached line and marks it dirty. It responds with `resp_hit`=0.
- R7: Evicting a dirty line first issues one next-level write of the whole old block, with all mask bits set, to that line's block address. The refill read comes after it.
- R8: In write-through mode (`wb_mode`=0), a write hit updates the cached word and issues one next-level write. That write carries a one-hot `mem_req_wmask` at the word index and the word replicated across `mem_req_wdata`.
- R9: In write-through mode, a write miss issues only that one-word next-level write and does not allocate a line, so a following read of the same block misses.
- R10: Reset clears every valid and dirty bit. After reset `req_ready`=1, `resp_valid`=0 and `mem_req_valid`=0.
- R11: A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low until the response. `resp_valid` is a one-cycle pulse. A next-level request holds its valid, address, write flag and data stable until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_mode | input | 1 | 1 = write-back/allocate, 0 = write-through/no-allocate |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8*WORD_BYTES | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | The access hit on first lookup |
| resp_rdata | output | 8*WORD_BYTES | Load data |
| mem_req_valid | output | 1 | Next-level request valid |
| mem_req_ready | input | 1 | Next-level request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = block read |
| mem_req_addr | output | ADDR_W | Next-level byte address |
| mem_req_wdata | output | 8*BLOCK_BYTES | Write data, word w at bits [w*WORD_W +: WORD_W] |
| mem_req_wmask | output | BLOCK_BYTES/WORD_BYTES | Per-word write enable |
| mem_resp_valid | input | 1 | Block read data valid |
| mem_resp_rdata | input | 8*BLOCK_BYTES | Block read data |

## Verification
The bench builds the cache with a 10-bit address, 4 sets, 2 ways, 16-byte blocks and 4-byte words. That makes 256 words behind a 4-bit tag, so a full sweep of memory in each policy takes only a few hundred accesses. The sweeps cover cold misses, in-block hits, evictions of dirty lines, write-through updates and bypassed write misses. They also run a three-tag conflict sequence in one set that exposes the least-recently-used order. The memory model stalls one cycle in three and answers reads two cycles late, so held requests are exercised as well.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FETCH,
        ST_FILL,
        ST_THRU,
        ST_DONE
    } cache_state_e;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tag[g] == tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] query_set,
    output logic [WAY_W-1:0] victim_way
);
    // rank 0 = most recent, WAYS-1 = oldest
    logic [WAY_W-1:0] rank_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[touch_set][w] <= '0;
                else if (rank_q[touch_set][w] < rank_q[touch_set][touch_way])
                    rank_q[touch_set][w] <= rank_q[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank_q[query_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_sa.sv
module cache_sa
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SETS        = 4,
    parameter int WAYS        = 2,
    parameter int BLOCK_BYTES = 16,
    parameter int WORD_BYTES  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wb_mode,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic                                 req_write,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [8*WORD_BYTES-1:0]              req_wdata,
    output logic                                 resp_valid,
    output logic                                 resp_hit,
    output logic [8*WORD_BYTES-1:0]              resp_rdata,
    output logic                                 mem_req_valid,
    input  logic                                 mem_req_ready,
    output logic                                 mem_req_write,
    output logic [ADDR_W-1:0]                    mem_req_addr,
    output logic [8*BLOCK_BYTES-1:0]             mem_req_wdata,
    output logic [BLOCK_BYTES/WORD_BYTES-1:0]    mem_req_wmask,
    input  logic                                 mem_resp_valid,
    input  logic [8*BLOCK_BYTES-1:0]             mem_resp_rdata
);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int LSB_W  = $clog2(WORD_BYTES);
    localparam int WORDS  = BLOCK_BYTES / WORD_BYTES;
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int BLK_W  = 8 * BLOCK_BYTES;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

    cache_state_e state_q, state_d;

    logic              rq_write;
    logic [ADDR_W-1:0] rq_addr;
    logic [WORD_W-1:0] rq_wdata;
    logic              miss_q;
    logic [WORD_W-1:0] rdata_q;

    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [BLK_W-1:0]  data_q  [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];

    logic [SET_W-1:0]            rq_set;
    logic [TAG_W-1:0]            rq_tag;
    logic [OFF_W-LSB_W-1:0]      rq_word;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WAY_W-1:0]            victim;
    logic                        victim_dirty;
    logic                        touch_en;
    logic [WAY_W-1:0]            touch_way;

    assign rq_set  = rq_addr[OFF_W +: SET_W];
    assign rq_tag  = rq_addr[ADDR_W-1 -: TAG_W];
    assign rq_word = rq_addr[OFF_W-1:LSB_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[rq_set][w];
    end

    cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .way_tag   (set_tags),
        .way_valid (valid_q[rq_set]),
        .tag       (rq_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    assign touch_en  = (state_q == ST_LOOKUP && hit) || (state_q == ST_FILL && mem_resp_valid);
    assign touch_way = (state_q == ST_FILL) ? victim : hit_way;

    cache_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_set  (rq_set),
        .touch_way  (touch_way),
        .query_set  (rq_set),
        .victim_way (victim)
    );

    assign victim_dirty = valid_q[rq_set][victim] && dirty_q[rq_set][victim];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (rq_write && !wb_mode)  state_d = ST_THRU;
                else if (hit)              state_d = ST_DONE;
                else if (victim_dirty)     state_d = ST_EVICT;
                else                       state_d = ST_FETCH;
            end
            ST_EVICT:  if (mem_req_ready)  state_d = ST_FETCH;
            ST_FETCH:  if (mem_req_ready)  state_d = ST_FILL;
            ST_FILL:   if (mem_resp_valid) state_d = ST_LOOKUP;
            ST_THRU:   if (mem_req_ready)  state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        mem_req_wmask = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {tag_q[rq_set][victim], rq_set, {OFF_W{1'b0}}};
                mem_req_wdata = data_q[rq_set][victim];
                mem_req_wmask = '1;
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {rq_tag, rq_set, {OFF_W{1'b0}}};
            end
            ST_THRU: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = rq_addr;
                mem_req_wdata = {WORDS{rq_wdata}};
                mem_req_wmask = WORDS'(1) << rq_word;
            end
            ST_DONE:  resp_valid = 1'b1;
            default: ;
        endcase
    end

    assign resp_hit   = !miss_q;
    assign resp_rdata = rdata_q;

    // request capture and line status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_write <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
            miss_q   <= 1'b0;
            rdata_q  <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                rq_write <= req_write;
                rq_addr  <= req_addr;
                rq_wdata <= req_wdata;
                miss_q   <= 1'b0;
            end
            if (state_q == ST_LOOKUP) begin
                if (!hit) miss_q <= 1'b1;
                if (hit && !rq_write)
                    rdata_q <= data_q[rq_set][hit_way][rq_word*WORD_W +: WORD_W];
                if (hit && rq_write && wb_mode)
                    dirty_q[rq_set][hit_way] <= 1'b1;
            end
            if (state_q == ST_FILL && mem_resp_valid) begin
                valid_q[rq_set][victim] <= 1'b1;
                dirty_q[rq_set][victim] <= 1'b0;
            end
        end
    end

    // tag and data storage
    always_ff @(posedge clk) begin
        if (state_q == ST_LOOKUP && hit && rq_write)
            data_q[rq_set][hit_way][rq_word*WORD_W +: WORD_W] <= rq_wdata;
        if (state_q == ST_FILL && mem_resp_valid) begin
            data_q[rq_set][victim] <= mem_resp_rdata;
            tag_q[rq_set][victim]  <= rq_tag;
        end
    end
endmodule

// File: rtl/cache_sa_chk.sv
module cache_sa_chk #(
    parameter int ADDR_W      = 16,
    parameter int BLOCK_BYTES = 16,
    parameter int WORD_BYTES  = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wb_mode,
    input logic                              req_valid,
    input logic                              req_ready,
    input logic                              resp_valid,
    input logic                              mem_req_valid,
    input logic                              mem_req_ready,
    input logic                              mem_req_write,
    input logic [ADDR_W-1:0]                 mem_req_addr,
    input logic [8*BLOCK_BYTES-1:0]          mem_req_wdata,
    input logic [BLOCK_BYTES/WORD_BYTES-1:0] mem_req_wmask
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R3
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write |-> mem_req_addr[OFF_W-1:0] == '0);

    // R7
    evict_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write && wb_mode |-> &mem_req_wmask);

    // R8
    thru_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write && !wb_mode |-> $onehot(mem_req_wmask));
endmodule

bind cache_sa cache_sa_chk #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wb_mode       (wb_mode),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_wmask (mem_req_wmask)
);

// File: tb/cache_sa_test.sv
module cache_sa_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int NW = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wb_mode = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid, resp_hit;
    logic [31:0]  resp_rdata;
    logic         mem_req_valid, mem_req_write;
    logic         mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic [3:0]   mem_req_wmask;
    logic         mem_resp_valid = 1'b0;
    logic [127:0] mem_resp_rdata = '0;

    cache_sa #(.ADDR_W(AW), .SETS(4), .WAYS(2), .BLOCK_BYTES(16), .WORD_BYTES(4)) uut (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_wmask(mem_req_wmask),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mem_arr [NW];
    logic [31:0] shadow  [NW];
    logic [3:0]  mtag    [4][2];
    bit          mval    [4][2];
    bit          mdirty  [4][2];
    int          mem_wr_cnt = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    string       ovr = "";

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", rq, got, exp);
        end
    endtask

    // next-level memory: stalls one cycle in three, reads answer two cycles late
    initial begin
        int cyc = 0;
        int rd_wait = 0;
        logic [7:0] rd_base = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_resp_valid = 1'b0;
            if (!rst_n) rd_wait = 0;
            if (rd_wait > 0) begin
                rd_wait--;
                if (rd_wait == 0) begin
                    for (int k = 0; k < 4; k++) mem_resp_rdata[k*32 +: 32] = mem_arr[rd_base + 8'(k)];
                    mem_resp_valid = 1'b1;
                end
            end
            mem_req_ready = (cyc % 3) != 1;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    for (int k = 0; k < 4; k++)
                        if (mem_req_wmask[k])
                            mem_arr[{mem_req_addr[AW-1:4], 2'(k)}] = mem_req_wdata[k*32 +: 32];
                    mem_wr_cnt++;
                end else begin
                    rd_base = {mem_req_addr[AW-1:4], 2'b00};
                    rd_wait = 2;
                end
            end
        end
    end

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0;
        wb_mode = mode;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin mval[s][w] = 0; mdirty[s][w] = 0; end
        repeat (3) @(negedge clk);
        chk("R10", 32'(req_ready), 32'd1);
        chk("R10", 32'(resp_valid), 32'd0);
        chk("R10", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [31:0] d);
        logic [1:0] s = a[5:4];
        logic [3:0] t = a[9:6];
        logic [7:0] wi = a[9:2];
        int hw = -1;
        bit exp_hit, ev = 0, dd;
        int exp_wr = 0;
        logic [3:0] evtag = '0;
        string lab;
        int base;
        logic got_hit;
        logic [31:0] got_data;
        if (mval[s][0] && mtag[s][0] == t) hw = 0;
        else if (mval[s][1] && mtag[s][1] == t) hw = 1;
        exp_hit = (hw >= 0);
        if (hw >= 0) begin
            dd = mdirty[s][hw];
            if (hw == 1) begin
                mtag[s][1] = mtag[s][0]; mval[s][1] = mval[s][0]; mdirty[s][1] = mdirty[s][0];
                mtag[s][0] = t; mval[s][0] = 1; mdirty[s][0] = dd;
            end
            if (wr && wb_mode) mdirty[s][0] = 1;
            if (wr && !wb_mode) exp_wr = 1;
            lab = !wr ? "R2" : (wb_mode ? "R5" : "R8");
        end else if (wr && !wb_mode) begin
            exp_wr = 1;
            lab = "R9";
        end else begin
            if (mval[s][1] && mdirty[s][1]) begin exp_wr = 1; ev = 1; evtag = mtag[s][1]; end
            mtag[s][1] = mtag[s][0]; mval[s][1] = mval[s][0]; mdirty[s][1] = mdirty[s][0];
            mtag[s][0] = t; mval[s][0] = 1; mdirty[s][0] = wr;
            lab = ev ? "R7" : (wr ? "R6" : "R3");
        end
        if (ovr != "") lab = ovr;
        if (wr) shadow[wi] = d;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        base = mem_wr_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", 32'(req_ready), 32'd0);
        while (!resp_valid) @(negedge clk);
        got_hit = resp_hit;
        got_data = resp_rdata;
        chk(lab, 32'(got_hit), 32'(exp_hit));
        if (!wr) chk(lab, got_data, shadow[wi]);
        chk(lab, 32'(mem_wr_cnt - base), 32'(exp_wr));
        if (wr && !wb_mode) chk(lab, mem_arr[wi], d);
        if (ev)
            for (int k = 0; k < 4; k++)
                chk("R7", mem_arr[{evtag, s, 2'(k)}], shadow[{evtag, s, 2'(k)}]);
    endtask

    task automatic run_phase(input bit mode);
        do_reset(mode);
        ovr = "";
        for (int i = 0; i < NW; i++) access(0, 10'(i*4), 32'h0);
        ovr = "R1";
        access(0, 10'h104, 32'h0);
        access(0, 10'h105, 32'h0);
        access(0, 10'h107, 32'h0);
        access(0, 10'h10A, 32'h0);
        ovr = "";
        for (int i = 0; i < NW; i += 3)
            access(1, 10'(i*4), 32'h5A00_0000 ^ (32'(i) * 32'd7919) ^ (32'(mode) << 20));
        for (int i = 0; i < NW; i++) access(0, 10'(i*4), 32'h0);
        ovr = "R4";
        access(0, 10'h050, 32'h0);
        access(0, 10'h090, 32'h0);
        access(0, 10'h050, 32'h0);
        access(0, 10'h0D0, 32'h0);
        access(0, 10'h054, 32'h0);
        access(0, 10'h094, 32'h0);
        ovr = "";
        access(1, 10'h258, 32'hC0DE_0000 | 32'(mode));
        access(0, 10'h258, 32'h0);
        access(1, 10'h25C, 32'hBEEF_0000 | 32'(mode));
        access(0, 10'h25C, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            mem_arr[i] = (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
            shadow[i]  = mem_arr[i];
        end
        run_phase(1'b0);
        run_phase(1'b1);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R11 watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule